// File: doc/BRIEF.md
# Two-Level Segment/Page Address Walker

This block turns a CPU virtual address into a physical memory address by walking two tables in memory. It reads the descriptor of the addressed segment first and checks that the segment is resident and that the requested access is allowed. It then reads the page-table entry for the addressed page. If the page is resident, the block performs the actual data read or write at the translated address. All three accesses go through one shared memory master port, one after another.

Each CPU access is a request/response transaction. The response carries a two-bit outcome code. An access that fails at any stage ends at once and reports the class of failure. No later table read is made, and no data access is issued. The base of the segment table comes from a register outside the block (`segBase`).

Top module: `spt_top`

## Requirements
- R1: The 16-bit virtual address is split as follows: segment = `reqVaddr[15:12]`, page = `reqVaddr[11:8]`, byte offset = `reqVaddr[7:0]`.
- R2: The first memory transaction of every access is a read at `segBase + segment`. The descriptor word is laid out as bit 15 resident, bit 14 read allowed, bit 13 write allowed, and bits 12:0 the page-table base.
- R3: If the descriptor's resident bit is 0, the response carries code 01 (segment fault), and the access uses exactly one memory transaction.
- R4: If the segment is resident but the permission bit for the access type is 0 (bit 14 for reads, bit 13 for writes), the response carries code 10 (protection trap), after exactly one transaction. A non-resident segment reports 01 even when its permission bits are also 0.
- R5: The second transaction is a read at `pageTableBase + page`. The entry word is laid out as bit 15 resident and bits 7:0 the frame number.
- R6: If the page entry's resident bit is 0, the response carries code 11 (page fault), after exactly two transactions.
- R7: On success, the third transaction goes to `frame*256 + offset`, and the response code is 00. For a write, this transaction has `memWrite`=1 and carries `reqWdata`. For a read, the data returned by memory appears on `rspRdata`. No transaction follows the third.
- R8: `reqReady` is high only while the walker is idle. A request is accepted only then, and no memory transaction is issued while idle.
- R9: A memory request is held with a stable address until `memReady` is seen. Read data is accepted only on `memRvalid`, after any latency. `rspValid` is a pulse of exactly one cycle.
- R10: After reset, `reqReady`=1, `rspValid`=0 and `memValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segBase | input | 16 | Segment table base address |
| reqValid | input | 1 | CPU request valid |
| reqReady | output | 1 | Walker idle, request taken |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqVaddr | input | 16 | Virtual address |
| reqWdata | input | 16 | Store data |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 2 | 00 ok, 01 segment, 10 protection, 11 page |
| rspRdata | output | 16 | Load data |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory request accepted |
| memWrite | output | 1 | Memory request is a store |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory store data |
| memRvalid | input | 1 | Memory read data valid |
| memRdata | input | 16 | Memory read data |

## Verification
Each result is due at a time that depends on the memory handshake, not at a fixed cycle count. `reqReady` drops in the cycle right after the accepting edge. Each table read finishes in the cycle after `memRvalid` is seen. `rspValid` rises one cycle after the last memory event. The bench samples every output on the falling edge and waits for the `rspValid` pulse. It then checks that the pulse is gone one cycle later. Only after that does it compare the fault code, the data and the logged transactions. The memory model stalls `memReady` and varies read latency, so each wait state and each held request is exercised.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEG_RD, ST_PT_RD, ST_DATA, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_SEG  = 2'b01,
    FLT_PROT = 2'b10,
    FLT_PAGE = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    SEL_SEG, SEL_PT, SEL_DATA
  } addr_sel_e;

  typedef struct packed {
    logic      capReq;
    logic      loadDesc;
    logic      loadPte;
    logic      capData;
    addr_sel_e addrSel;
  } walk_ctl_t;

endpackage

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isWrite,
  input  logic      memReady,
  input  logic      memRvalid,
  input  logic      rdPresent,
  input  logic      rdPermOk,
  output logic      reqReady,
  output logic      memValid,
  output logic      memWrite,
  output logic      rspValid,
  output logic [1:0] rspFault,
  output walk_ctl_t ctl
);

  walk_state_e state;
  logic        issued;
  fault_e      faultQ;
  logic        rdDone;
  logic        memFire;

  assign memFire = memValid && memReady;
  assign rdDone  = issued && memRvalid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
      faultQ <= FLT_NONE;
    end else begin
      if (memFire) issued <= 1'b1;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state  <= ST_SEG_RD;
          issued <= 1'b0;
        end
        ST_SEG_RD: if (rdDone) begin
          issued <= 1'b0;
          if (!rdPresent) begin
            faultQ <= FLT_SEG;
            state  <= ST_FAULT;
          end else if (!rdPermOk) begin
            faultQ <= FLT_PROT;
            state  <= ST_FAULT;
          end else begin
            state <= ST_PT_RD;
          end
        end
        ST_PT_RD: if (rdDone) begin
          issued <= 1'b0;
          if (!rdPresent) begin
            faultQ <= FLT_PAGE;
            state  <= ST_FAULT;
          end else begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (isWrite ? memFire : rdDone) begin
            issued <= 1'b0;
            state  <= ST_DONE;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady = (state == ST_IDLE);
    memValid = !issued &&
               (state == ST_SEG_RD || state == ST_PT_RD || state == ST_DATA);
    memWrite = (state == ST_DATA) && isWrite;
    rspValid = (state == ST_DONE) || (state == ST_FAULT);
    rspFault = (state == ST_FAULT) ? faultQ : FLT_NONE;

    ctl.capReq   = (state == ST_IDLE) && reqValid;
    ctl.loadDesc = (state == ST_SEG_RD) && rdDone;
    ctl.loadPte  = (state == ST_PT_RD) && rdDone;
    ctl.capData  = (state == ST_DATA) && !isWrite && rdDone;
    unique case (state)
      ST_PT_RD: ctl.addrSel = SEL_PT;
      ST_DATA:  ctl.addrSel = SEL_DATA;
      default:  ctl.addrSel = SEL_SEG;
    endcase
  end

endmodule

// File: rtl/spt_dp.sv
module spt_dp
  import spt_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 8,
  parameter int PA_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_ctl_t         ctl,
  input  logic [PA_W-1:0]   segBase,
  input  logic              reqWrite,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] reqVaddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              isWrite,
  output logic              rdPresent,
  output logic              rdPermOk,
  output logic [PA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int VA_W   = SEG_W + PAGE_W + OFF_W;
  localparam int PTB_W  = DATA_W - 3;
  localparam int FRM_W  = PA_W - OFF_W;

  logic [VA_W-1:0]   vaddrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [PTB_W-1:0]  ptBaseQ;
  logic [FRM_W-1:0]  frameQ;
  logic [DATA_W-1:0] rdataQ;

  logic [SEG_W-1:0]  segIdx;
  logic [PAGE_W-1:0] pageIdx;
  logic [OFF_W-1:0]  byteOff;

  assign segIdx  = vaddrQ[VA_W-1 -: SEG_W];
  assign pageIdx = vaddrQ[OFF_W +: PAGE_W];
  assign byteOff = vaddrQ[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      isWrite <= 1'b0;
      wdataQ  <= '0;
      ptBaseQ <= '0;
      frameQ  <= '0;
      rdataQ  <= '0;
    end else begin
      if (ctl.capReq) begin
        vaddrQ  <= reqVaddr;
        isWrite <= reqWrite;
        wdataQ  <= reqWdata;
      end
      if (ctl.loadDesc) ptBaseQ <= memRdata[PTB_W-1:0];
      if (ctl.loadPte)  frameQ  <= memRdata[FRM_W-1:0];
      if (ctl.capData)  rdataQ  <= memRdata;
    end
  end

  // Descriptor and page entry share the resident flag in the top bit.
  assign rdPresent = memRdata[DATA_W-1];
  assign rdPermOk  = isWrite ? memRdata[DATA_W-3] : memRdata[DATA_W-2];

  always_comb begin
    unique case (ctl.addrSel)
      SEL_PT:   memAddr = PA_W'(ptBaseQ) + PA_W'(pageIdx);
      SEL_DATA: memAddr = (PA_W'(frameQ) << OFF_W) + PA_W'(byteOff);
      default:  memAddr = segBase + PA_W'(segIdx);
    endcase
  end

  assign memWdata = wdataQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/spt_top.sv
module spt_top
  import spt_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 8,
  parameter int PA_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PA_W-1:0]   segBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] reqVaddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [PA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata
);

  walk_ctl_t ctl;
  logic      isWrite;
  logic      rdPresent;
  logic      rdPermOk;

  spt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isWrite(isWrite),
    .memReady(memReady), .memRvalid(memRvalid), .rdPresent(rdPresent),
    .rdPermOk(rdPermOk), .reqReady(reqReady), .memValid(memValid),
    .memWrite(memWrite), .rspValid(rspValid), .rspFault(rspFault),
    .ctl(ctl)
  );

  spt_dp #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .PA_W(PA_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .segBase(segBase),
    .reqWrite(reqWrite), .reqVaddr(reqVaddr), .reqWdata(reqWdata),
    .memRdata(memRdata), .isWrite(isWrite), .rdPresent(rdPresent),
    .rdPermOk(rdPermOk), .memAddr(memAddr), .memWdata(memWdata),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/spt_chk.sv
module spt_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic [1:0]      rspFault,
  input logic            memValid,
  input logic            memReady,
  input logic            memWrite,
  input logic [PA_W-1:0] memAddr
);

  logic [2:0] txnCnt;

  always_ff @(posedge clk) begin
    if (!rstN) txnCnt <= '0;
    else if (reqValid && reqReady) txnCnt <= '0;
    else if (memValid && memReady) txnCnt <= txnCnt + 3'd1;
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite))); // R9
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memValid); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R8
  AST_SEG_FAULT_ONE_TXN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'b01) |-> txnCnt == 3'd1); // R3
  AST_PROT_ONE_TXN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'b10) |-> txnCnt == 3'd1); // R4
  AST_PAGE_FAULT_TWO_TXN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'b11) |-> txnCnt == 3'd2); // R6
  AST_OK_THREE_TXN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'b00) |-> txnCnt == 3'd3); // R7
  AST_STORE_IS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> txnCnt == 3'd2); // R7

endmodule

bind spt_top spt_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspFault(rspFault), .memValid(memValid),
  .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr)
);

// File: tb/sim_spt_top.sv
`timescale 1ns/1ps
module sim_spt_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] segBase = 16'h0400;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [15:0] reqVaddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [1:0]  rspFault;
  logic [15:0] rspRdata;
  logic        memValid;
  logic        memReady;
  logic        memWrite;
  logic [15:0] memAddr;
  logic [15:0] memWdata;
  logic        memRvalid = 1'b0;
  logic [15:0] memRdata = '0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  spt_top u0 (
    .clk(clk), .rstN(rstN), .segBase(segBase), .reqValid(reqValid),
    .reqReady(reqReady), .reqWrite(reqWrite), .reqVaddr(reqVaddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspFault(rspFault),
    .rspRdata(rspRdata), .memValid(memValid), .memReady(memReady),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRdata(memRdata)
  );

  // Memory contents are computed from the address.
  function automatic logic [15:0] memFn(input logic [15:0] a);
    int s, p;
    if (a >= segBase && a < segBase + 16'd16) begin
      s = int'(a - segBase);
      return {s != 3, s != 5, s != 6, 13'(16'h0800 + s * 16)};
    end else if (a >= 16'h0800 && a < 16'h0900) begin
      s = int'(a[7:4]);
      p = int'(a[3:0]);
      return {p != 9, 7'd0, 8'({a[7:4], a[3:0]} ^ 8'h5A)};
    end
    return a ^ 16'hC3C3;
  endfunction

  logic [7:0]  rdyCnt = '0;
  logic [7:0]  lfsr = 8'h1D;
  logic        pend = 1'b0;
  logic [1:0]  delay = '0;
  logic [15:0] pendAddr = '0;
  int          txnIdx = 0;
  logic [15:0] logAddr [3];
  logic        logWr [3];
  logic [15:0] logWdata [3];

  assign memReady = (rdyCnt[1:0] != 2'd0);

  always @(posedge clk) begin
    rdyCnt <= rdyCnt + 8'd1;
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memRvalid <= 1'b0;
    if (pend) begin
      if (delay == 2'd0) begin
        memRvalid <= 1'b1;
        memRdata  <= memFn(pendAddr);
        pend      <= 1'b0;
      end else begin
        delay <= delay - 2'd1;
      end
    end
    if (reqValid && reqReady) txnIdx <= 0;
    else if (memValid && memReady) begin
      if (txnIdx < 3) begin
        logAddr[txnIdx]  <= memAddr;
        logWr[txnIdx]    <= memWrite;
        logWdata[txnIdx] <= memWdata;
      end
      txnIdx <= txnIdx + 1;
      if (!memWrite) begin
        pend     <= 1'b1;
        pendAddr <= memAddr;
        delay    <= lfsr[1:0];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic runOne(input int s, input int p, input int off, input bit wr);
    int wait_n;
    int expCode, expTxn;
    logic [15:0] pa, wd;
    wd = 16'(s * 4099 + p * 257 + off + (wr ? 16'h8000 : 0));
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqVaddr = {4'(s), 4'(p), 8'(off)};
    reqWdata = wd;
    wait_n = 0;
    while (!reqReady) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    reqValid = 1'b0;
    reqVaddr = 16'hFFFF;
    reqWdata = 16'h0000;
    check(reqReady == 1'b0, "R8 busy after accept", reqReady, 0);
    wait_n = 0;
    while (!rspValid && wait_n < 300) begin @(negedge clk); wait_n++; end
    if (!rspValid) begin
      check(1'b0, "R9 response timeout", wait_n, 0);
      summary();
    end
    begin
      logic [1:0]  gotCode = rspFault;
      logic [15:0] gotData = rspRdata;
      @(negedge clk);
      check(rspValid == 1'b0, "R9 single-cycle response", rspValid, 0);
      if (s == 3) begin expCode = 1; expTxn = 1; end
      else if (wr ? (s == 6) : (s == 5)) begin expCode = 2; expTxn = 1; end
      else if (p == 9) begin expCode = 3; expTxn = 2; end
      else begin expCode = 0; expTxn = 3; end
      check(gotCode == 2'(expCode),
            expCode == 1 ? "R3 code" : expCode == 2 ? "R4 code" :
            expCode == 3 ? "R6 code" : "R7 code", gotCode, expCode);
      check(txnIdx == expTxn,
            expCode == 1 ? "R3 txn count" : expCode == 2 ? "R4 txn count" :
            expCode == 3 ? "R6 txn count" : "R7 txn count", txnIdx, expTxn);
      check(logAddr[0] == segBase + 16'(s) && !logWr[0], "R1 R2 descriptor address",
            logAddr[0], segBase + 16'(s));
      if (expTxn >= 2)
        check(logAddr[1] == 16'(16'h0800 + s * 16 + p) && !logWr[1],
              "R5 page entry address", logAddr[1], 16'h0800 + s * 16 + p);
      if (expTxn == 3) begin
        pa = {8'({4'(s), 4'(p)} ^ 8'h5A), 8'(off)};
        check(logAddr[2] == pa && logWr[2] == wr, "R7 data address", logAddr[2], pa);
        if (wr) check(logWdata[2] == wd, "R7 store data", logWdata[2], wd);
        else    check(gotData == memFn(pa), "R7 load data", gotData, memFn(pa));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R10 reqReady in reset", reqReady, 1);
    check(rspValid == 1'b0, "R10 rspValid in reset", rspValid, 0);
    check(memValid == 1'b0, "R10 memValid in reset", memValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(memValid == 1'b0, "R10 memValid after reset", memValid, 0);
    for (int s = 0; s < 16; s++)
      for (int p = 0; p < 16; p++)
        for (int w = 0; w < 2; w++)
          runOne(s, p, (s * 37 + p * 11 + w * 101) % 256, w[0]);
    segBase = 16'h0C30;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 2; w++) begin
        runOne(s, 4, 0, w[0]);
        runOne(s, 15, 255, w[0]);
      end
    summary();
  end

endmodule